// File: doc/BRIEF.md
# Host and Expansion-Slot Bus Arbiter

This block decides who owns a shared system bus that one host processor and several expansion slots all want to use. Each slot has its own active-low request and grant wires. The processor uses an active-low request, an active-low grant and an active-low busy signal. The arbiter drives the busy signal low through an enable output and otherwise leaves it undriven. When nobody else is asking, the processor is parked on the bus: its grant stays asserted and the arbiter does not drive busy.

The processor takes part in arbitration as requester index 0, and slot k is requester index k+1. Arbitration is round-robin, and the most recent winner drops to the lowest priority. A decision is taken only when the bus is idle. That means the processor's busy input is high and the synchronised FRAME_n and IRDY_n are both high. A move from one owner to a different one always passes through one clock in which no grant is asserted. A slot that is granted must start its cycle within a bounded number of clocks. If it does not, its grant is taken away and the other requesters get their turn.

Top module: `pci_host_arbiter`

## Requirements
- R1: After reset, and whenever no request is pending, the processor grant is low, every slot grant is high and the busy drive enable is 0.
- R2: When the processor wins, its grant stays low and no slot grant is issued for as long as its request stays low. A slot that is still pending is granted 5 clocks after the processor request goes high.
- R3: No new grant is issued while the processor busy input is low, or while FRAME_n or IRDY_n is low. Once the bus is idle, a pending slot grant appears 4 clocks after the blocking input is released.
- R4: At most one grant (processor or slot) is low at any time. Every slot grant is preceded by a clock in which the processor grant and all slot grants are high.
- R5: The busy drive enable is 1 exactly while a slot grant is low.
- R6: Priority is round-robin over the indices, with the processor at index 0 and slot k at index k+1. The search starts at the index after the last winner, and the last winner is index 0 after reset. With all slots requesting continuously, grants go to slots 0,1,2,3,4,0,...
- R7: A slot that holds its grant without FRAME_n low for GRANT_TIMEOUT (default 16) clocks loses the grant after exactly that many clocks. Arbitration then continues with the next requester in round-robin order.
- R8: Once FRAME_n is seen low during a grant, the grant and the busy drive are held until FRAME_n and IRDY_n are both high. The grant then goes high 3 clocks after the inputs are released.
- R9: Every request and bus input passes through a 2-stage synchroniser. A slot request made while parked makes the processor grant go high 3 clocks later and the slot grant go low 4 clocks later.
- R10: A slot that raises its request while granted, before FRAME_n is seen low, loses its grant 3 clocks later. The processor grant returns one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| cpu_bus_req_n | input | 1 | Processor bus request, active low |
| cpu_busy_in_n | input | 1 | Level seen on the shared busy line while the processor drives it, active low |
| cpu_bus_gnt_n | output | 1 | Processor bus grant, active low |
| busy_pull_en | output | 1 | When 1, the busy line is driven low; when 0, it is left undriven |
| slot_want_n | input | N_SLOTS | Per-slot bus request, active low |
| slot_grant_n | output | N_SLOTS | Per-slot bus grant, active low |
| pci_frame_n | input | 1 | PCI FRAME_n, active low |
| pci_irdy_n | input | 1 | PCI IRDY_n, active low |

## Verification
A corrupted round-robin pointer appears at the ports as a wrong slot on the very next grant. The bench therefore follows two full rotations. A wrong state-machine transition breaks either the one-clock gap with no grant or the fixed 3-, 4- and 5-clock latencies, and those are sampled on exact clocks. An off-by-one in the grant timer or in the synchroniser depth changes the number of clocks a grant is held, and that count is compared exactly. A broken idle check shows up as a grant issued while the bus is busy, within the 20 clocks during which the bench holds the bus busy.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [2:0] {
    ST_PARK      = 3'd0,
    ST_HOST      = 3'd1,
    ST_GAP       = 3'd2,
    ST_SLOT_WAIT = 3'd3,
    ST_SLOT_RUN  = 3'd4
  } arb_state_e;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_REQ = 6,
  parameter int IW    = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req,
  input  logic [IW-1:0]    last,
  output logic             any_req,
  output logic [IW-1:0]    win
);

  always_comb begin
    logic found;
    found = 1'b0;
    win   = '0;
    for (int k = 1; k <= N_REQ; k++) begin
      int idx;
      idx = int'(last) + k;
      if (idx >= N_REQ) idx = idx - N_REQ;
      if (!found && req[idx]) begin
        found = 1'b1;
        win   = IW'(idx);
      end
    end
  end

  assign any_req = |req;

  // R6: whoever is picked must actually be requesting
  always_comb begin
    if (any_req) begin
      p_win_requests_r6: assert (req[win]);
    end
  end

endmodule

// File: rtl/arb_grant_timer.sv
module arb_grant_timer #(
  parameter int LIMIT = 16,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = arm || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!arm)        cnt_d = '0;
    else if (!expire) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = arm && (cnt_q == CW'(LIMIT - 1));

  p_timer_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT));

  p_timer_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> cnt_q == '0);

endmodule

// File: rtl/pci_host_arbiter.sv
module pci_host_arbiter import arb_pkg::*; #(
  parameter int N_SLOTS       = 5,
  parameter int GRANT_TIMEOUT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_bus_req_n,
  input  logic               cpu_busy_in_n,
  output logic               cpu_bus_gnt_n,
  output logic               busy_pull_en,
  input  logic [N_SLOTS-1:0] slot_want_n,
  output logic [N_SLOTS-1:0] slot_grant_n,
  input  logic               pci_frame_n,
  input  logic               pci_irdy_n
);

  localparam int N_REQ  = N_SLOTS + 1;
  localparam int IW     = $clog2(N_REQ);
  localparam int SYNC_W = N_SLOTS + 4;

  // ---------------- input synchronisation (R9)
  logic [SYNC_W-1:0]  sync_q;
  logic [N_SLOTS-1:0] want_s;
  logic               cpu_req_s, cpu_busy_s, frame_s, irdy_s;

  arb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL({SYNC_W{1'b1}})) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pci_irdy_n, pci_frame_n, cpu_busy_in_n, cpu_bus_req_n, slot_want_n}),
    .q     (sync_q)
  );

  assign want_s     = sync_q[N_SLOTS-1:0];
  assign cpu_req_s  = sync_q[N_SLOTS];
  assign cpu_busy_s = sync_q[N_SLOTS+1];
  assign frame_s    = sync_q[N_SLOTS+2];
  assign irdy_s     = sync_q[N_SLOTS+3];

  logic pci_active, bus_idle;
  assign pci_active = !frame_s || !irdy_s;
  assign bus_idle   = cpu_busy_s && !pci_active;

  // ---------------- round-robin pick (R6)
  logic [N_REQ-1:0] req_vec;
  logic [IW-1:0]    last_q, win;
  logic             any_req;

  assign req_vec = {~want_s, ~cpu_req_s};

  arb_rr_pick #(.N_REQ(N_REQ), .IW(IW)) u_pick (
    .req     (req_vec),
    .last    (last_q),
    .any_req (any_req),
    .win     (win)
  );

  // ---------------- grant timer (R7)
  arb_state_e state_q, state_d;
  logic       tmr_expire;

  arb_grant_timer #(.LIMIT(GRANT_TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (state_q == ST_SLOT_WAIT),
    .expire (tmr_expire)
  );

  // ---------------- next state
  logic [IW-1:0] owner_q, owner_d;
  logic          to_slot_q, to_slot_d;
  logic          pick_fire, owner_en, to_slot_en;
  logic          owner_left;

  assign owner_left = want_s[owner_q];

  always_comb begin
    state_d    = state_q;
    owner_d    = owner_q;
    to_slot_d  = to_slot_q;
    pick_fire  = 1'b0;
    unique case (state_q)
      ST_PARK: begin
        if (bus_idle && any_req) begin
          pick_fire = 1'b1;
          if (win == '0) begin
            state_d = ST_HOST;
          end else begin
            state_d   = ST_GAP;
            owner_d   = win - IW'(1);
            to_slot_d = 1'b1;
          end
        end
      end
      ST_HOST: begin
        if (cpu_req_s) state_d = ST_PARK;
      end
      ST_GAP: begin
        state_d = to_slot_q ? ST_SLOT_WAIT : ST_PARK;
      end
      ST_SLOT_WAIT: begin
        if (!frame_s) begin
          state_d = ST_SLOT_RUN;
        end else if (tmr_expire || owner_left) begin
          state_d   = ST_GAP;
          to_slot_d = 1'b0;
        end
      end
      ST_SLOT_RUN: begin
        if (!pci_active) begin
          state_d   = ST_GAP;
          to_slot_d = 1'b0;
        end
      end
      default: state_d = ST_PARK;
    endcase
  end

  assign owner_en   = pick_fire;
  assign to_slot_en = (state_d == ST_GAP) && (state_q != ST_GAP);

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PARK;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= '0;
    else if (pick_fire) last_q <= win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner_q <= '0;
    else if (owner_en) owner_q <= owner_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          to_slot_q <= 1'b0;
    else if (to_slot_en) to_slot_q <= to_slot_d;
  end

  // ---------------- outputs
  logic slot_owned;
  assign slot_owned    = (state_q == ST_SLOT_WAIT) || (state_q == ST_SLOT_RUN);
  assign cpu_bus_gnt_n = !((state_q == ST_PARK) || (state_q == ST_HOST));
  assign busy_pull_en  = slot_owned;

  genvar g;
  generate
    for (g = 0; g < N_SLOTS; g++) begin : g_grant
      assign slot_grant_n[g] = !(slot_owned && (owner_q == IW'(g)));
    end
  endgenerate

  // ---------------- assertions
  logic any_slot_gnt;
  assign any_slot_gnt = !(&slot_grant_n);

  p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~slot_grant_n, ~cpu_bus_gnt_n}));

  p_gap_before_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_slot_gnt) |-> ($past(cpu_bus_gnt_n) && $past(&slot_grant_n)));

  p_idle_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK && !bus_idle) |=> (state_q == ST_PARK));

  p_host_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOST && !cpu_req_s) |=> (state_q == ST_HOST));

  p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOT_WAIT && frame_s && tmr_expire) |=> !any_slot_gnt);

  p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOT_RUN && pci_active) |=> $stable(slot_grant_n));

  p_withdraw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOT_WAIT && frame_s && owner_left) |=> !any_slot_gnt);

endmodule

// File: tb/pci_host_arbiter_tb.sv
module pci_host_arbiter_tb;

  localparam int NS = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_bus_req_n, cpu_busy_in_n, cpu_bus_gnt_n, busy_pull_en;
  logic [NS-1:0] slot_want_n, slot_grant_n;
  logic          pci_frame_n, pci_irdy_n;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pci_host_arbiter #(.N_SLOTS(NS), .GRANT_TIMEOUT(16), .SYNC_STAGES(2)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_bus_req_n (cpu_bus_req_n),
    .cpu_busy_in_n (cpu_busy_in_n),
    .cpu_bus_gnt_n (cpu_bus_gnt_n),
    .busy_pull_en  (busy_pull_en),
    .slot_want_n   (slot_want_n),
    .slot_grant_n  (slot_grant_n),
    .pci_frame_n   (pci_frame_n),
    .pci_irdy_n    (pci_irdy_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cpu_bus_req_n = 1'b1; cpu_busy_in_n = 1'b1;
    slot_want_n = '1; pci_frame_n = 1'b1; pci_irdy_n = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic wait_any_slot(output int idx, output int waited, input int limit);
    idx = -1; waited = 0;
    while (idx < 0 && waited < limit) begin
      tick(1);
      waited++;
      for (int i = 0; i < NS; i++) if (!slot_grant_n[i]) idx = i;
    end
  endtask

  task automatic wait_release(input int limit);
    int w;
    w = 0;
    while (slot_grant_n != '1 && w < limit) begin
      tick(1);
      w++;
    end
  endtask

  task automatic short_cycle(input int len);
    pci_frame_n = 1'b0;
    tick(len);
    pci_frame_n = 1'b1;
    wait_release(20);
  endtask

  // R4/R5 monitor: each new slot grant follows an all-off clock, is alone, and drives busy
  bit prev_all_off = 1'b1;
  bit prev_any     = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit any_now;
      any_now = (slot_grant_n != '1);
      if (any_now && !prev_any) begin
        chk(prev_all_off && $countones(~slot_grant_n) == 1 && cpu_bus_gnt_n,
            "R4 gap/single grant", $countones(~slot_grant_n), 1);
        chk(busy_pull_en == 1'b1, "R5 busy with grant", busy_pull_en, 1);
      end
      if (!any_now && busy_pull_en) chk(1'b0, "R5 busy without grant", 1, 0);
      prev_any     = any_now;
      prev_all_off = !any_now && cpu_bus_gnt_n;
    end else begin
      prev_any = 1'b0; prev_all_off = 1'b1;
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int idx, w, cnt, bad, exp;

    // ---- R1 reset and idle park
    do_reset();
    chk(cpu_bus_gnt_n == 1'b0, "R1 parked grant", cpu_bus_gnt_n, 0);
    chk(slot_grant_n == '1, "R1 slot grants off", int'(slot_grant_n), 31);
    chk(busy_pull_en == 1'b0, "R1 busy undriven", busy_pull_en, 0);
    tick(10);
    chk(cpu_bus_gnt_n == 1'b0 && slot_grant_n == '1, "R1 idle stays parked", cpu_bus_gnt_n, 0);

    // ---- R9 latency, R4 gap, R7 timeout
    slot_want_n[0] = 1'b0; slot_want_n[1] = 1'b0;
    tick(3);
    chk(cpu_bus_gnt_n == 1'b1, "R9 park grant removed at 3", cpu_bus_gnt_n, 1);
    chk(slot_grant_n == '1, "R4 no grant in gap", int'(slot_grant_n), 31);
    tick(1);
    chk(slot_grant_n[0] == 1'b0, "R9 R6 slot0 granted at 4", slot_grant_n[0], 0);
    chk(busy_pull_en == 1'b1, "R5 busy drive", busy_pull_en, 1);
    cnt = 1;
    while (slot_grant_n[0] == 1'b0 && cnt < 40) begin
      tick(1);
      if (slot_grant_n[0] == 1'b0) cnt++;
    end
    chk(cnt == 16, "R7 grant held clocks", cnt, 16);
    slot_want_n[0] = 1'b1;
    wait_any_slot(idx, w, 20);
    chk(idx == 1, "R7 next requester after timeout", idx, 1);

    // ---- R8 grant held through the cycle
    pci_frame_n = 1'b0; slot_want_n[1] = 1'b1;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (slot_grant_n[1] != 1'b0 || !busy_pull_en) bad++;
    end
    chk(bad == 0, "R8 held during cycle", bad, 0);
    pci_irdy_n = 1'b0; pci_frame_n = 1'b1;
    tick(3);
    chk(slot_grant_n[1] == 1'b0, "R8 held while IRDY low", slot_grant_n[1], 0);
    pci_irdy_n = 1'b1;
    tick(2);
    chk(slot_grant_n[1] == 1'b0, "R8 held 2 clocks after release", slot_grant_n[1], 0);
    tick(1);
    chk(slot_grant_n[1] == 1'b1, "R8 released at 3", slot_grant_n[1], 1);

    // ---- R6 rotation over two rounds
    do_reset();
    slot_want_n = '0;
    for (int n = 0; n < 2 * NS; n++) begin
      exp = n % NS;
      wait_any_slot(idx, w, 40);
      chk(idx == exp, "R6 rotation order", idx, exp);
      short_cycle(2);
    end
    slot_want_n = '1;
    tick(6);

    // ---- R2 processor as requester
    do_reset();
    cpu_bus_req_n = 1'b0; slot_want_n[0] = 1'b0;
    wait_any_slot(idx, w, 20);
    chk(idx == 0, "R6 slot0 before host after reset", idx, 0);
    short_cycle(2);
    tick(2);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (cpu_bus_gnt_n != 1'b0 || slot_grant_n != '1) bad++;
    end
    chk(bad == 0, "R2 host keeps grant while requesting", bad, 0);
    cpu_bus_req_n = 1'b1;
    wait_any_slot(idx, w, 20);
    chk(idx == 0 && w == 5, "R2 slot granted 5 after host release", w, 5);
    slot_want_n[0] = 1'b1;
    short_cycle(2);

    // ---- R3 idle gating by processor busy, then by PCI activity
    do_reset();
    cpu_busy_in_n = 1'b0; slot_want_n[2] = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (slot_grant_n != '1 || cpu_bus_gnt_n != 1'b0) bad++;
    end
    chk(bad == 0, "R3 no grant while host busy", bad, 0);
    cpu_busy_in_n = 1'b1;
    wait_any_slot(idx, w, 20);
    chk(idx == 2 && w == 4, "R3 grant 4 after busy release", w, 4);
    slot_want_n[2] = 1'b1;
    short_cycle(2);
    tick(3);
    pci_frame_n = 1'b0; slot_want_n[3] = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (slot_grant_n != '1) bad++;
    end
    chk(bad == 0, "R3 no grant while FRAME low", bad, 0);
    pci_frame_n = 1'b1;
    wait_any_slot(idx, w, 20);
    chk(idx == 3 && w == 4, "R3 grant 4 after FRAME release", w, 4);

    // ---- R10 request withdrawn before the cycle starts
    slot_want_n[3] = 1'b1;
    tick(2);
    chk(slot_grant_n[3] == 1'b0, "R10 grant kept 2 clocks", slot_grant_n[3], 0);
    tick(1);
    chk(slot_grant_n[3] == 1'b1, "R10 grant removed at 3", slot_grant_n[3], 1);
    tick(1);
    chk(cpu_bus_gnt_n == 1'b0, "R10 host parked again", cpu_bus_gnt_n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule